// File: doc/BRIEF.md
# Snooping Four-State Cache Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped private cache whose owner shares a snooping bus with peer caches. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The controller serves processor read and write requests, decides whether each one hits, and issues the single bus transaction a miss or an upgrade needs. These transactions are a shared read, a read for ownership, an invalidate broadcast and a writeback. It also watches the transactions that peers place on the bus. It answers each snooped transaction with a "held here" indication, and with a defer indication when a peer tries to read a line that only this cache has up to date.

Line data, the memory behind the bus and arbitration between caches are handled elsewhere. The controller only tracks tags and states and drives the request side of the bus. It has one transaction in flight at a time. The processor port keeps `cpu_ready` low until the request can finish as a hit. An Exclusive line becomes Modified on a write without any bus traffic. A dirty line that a peer wants to read is written back first, and only then can the peer's retried read succeed.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus request is raised, `cpu_ready` is low while no request is presented, and a snoop to any address reports `snoop_shared` low.
- R2: A read whose address matches a held line completes in the cycle it is presented. In that cycle `cpu_ready` is high, no bus request follows, and the line state does not change. A line is held when it is Shared, Exclusive or Modified, and the line index is the low IDX_W address bits.
- R3: A write that hits a Modified or Exclusive line completes in the cycle it is presented, with no bus request. An Exclusive line becomes Modified.
- R4: A write that hits a Shared line issues an invalidate (bus op code 2) for its address. `cpu_ready` stays low until that completes, and the line is then Modified.
- R5: A snooped shared read (op code 0) of an Exclusive line moves it to Shared. Every snoop to a held line drives `snoop_shared` high in the same cycle.
- R6: A snooped read (op code 0 or 1) that hits a Modified line raises `snoop_defer` in the same cycle. If the controller is idle, it then issues a writeback (op code 3) of that address, and the line becomes Shared when the writeback completes. If the controller is busy, the read is deferred and no writeback is started.
- R7: A snooped invalidate (op code 2) or read for ownership (op code 1) of a Shared or Exclusive line moves it to Invalid.
- R8: A Shared line is never promoted to Exclusive. A later write to it still issues an invalidate even when no peer has claimed the line.
- R9: A read miss issues a shared read (op code 0). The line fills as Exclusive if `bus_shared` is low when `bus_done` is high, and as Shared otherwise.
- R10: A write miss issues a read for ownership (op code 1), and the line fills as Modified.
- R11: A miss whose line slot holds a Modified line first writes back the old address (op code 3) and then refills. A Shared or Exclusive occupant is dropped without bus traffic.
- R12: Only one bus transaction is outstanding at a time. Its op and address hold until `bus_done`, `cpu_ready` is low while it is pending, and a processor request presented in the same cycle as a snoop is held off for that cycle.
- R13: If a snoop invalidates a line while its upgrade invalidate is pending, the line is not made Modified. The still-presented write is then treated as a miss and issues a read for ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present, held until accepted |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes at this clock edge |
| bus_req_valid | output | 1 | Bus transaction pending |
| bus_req_op | output | 2 | 0 shared read, 1 read for ownership, 2 invalidate, 3 writeback |
| bus_req_addr | output | ADDR_W | Line address of the pending transaction |
| bus_done | input | 1 | Pending transaction finishes at this edge |
| bus_shared | input | 1 | A peer holds the line (sampled with bus_done) |
| snoop_valid | input | 1 | A peer transaction is visible on the bus |
| snoop_op | input | 2 | Op code of the snooped transaction |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_defer | output | 1 | Snooped read must be retried later |

## Verification
Hits and snoop responses are combinational: `cpu_ready`, `snoop_shared` and `snoop_defer` are due in the same cycle as the stimulus. Any bus request, including a snoop-triggered writeback, appears on the cycle after the request that caused it. After the edge where `bus_done` is high, the next phase starts, or `cpu_ready` rises for the retried hit one cycle later. The bench drives inputs on the falling edge and samples one time unit after it, so each check reads the cycle in which its result is due. Its model tracks, per line slot, the resident address and state, and it derives every expected op, address and response from that model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHD = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_RDS = 2'b00,
    BUS_RDX = 2'b01,
    BUS_INV = 2'b10,
    BUS_WB  = 2'b11
  } bus_op_e;

  function automatic logic is_held(line_st_e s);
    return s != LS_INV;
  endfunction

  function automatic logic can_write(line_st_e s);
    return (s == LS_MOD) || (s == LS_EXC);
  endfunction

  function automatic logic is_read_op(bus_op_e o);
    return (o == BUS_RDS) || (o == BUS_RDX);
  endfunction

  // State after a peer transaction hits a held line (Modified is handled by defer)
  function automatic line_st_e snoop_next(line_st_e s, bus_op_e o);
    line_st_e r;
    r = s;
    case (o)
      BUS_RDS: if (s == LS_EXC) r = LS_SHD;
      BUS_RDX, BUS_INV: if ((s == LS_SHD) || (s == LS_EXC)) r = LS_INV;
      default: r = s;
    endcase
    return r;
  endfunction

  function automatic line_st_e fill_state(logic wr, logic peer_has);
    if (wr) return LS_MOD;
    return peer_has ? LS_SHD : LS_EXC;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  localparam int NLINES = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_we,
  input  logic [IDX_W-1:0]      a_idx,
  input  logic                  a_tag_we,
  input  logic [TAG_W-1:0]      a_tag,
  input  line_st_e              a_st,
  input  logic                  s_we,
  input  logic [IDX_W-1:0]      s_idx,
  input  line_st_e              s_st,
  input  logic [IDX_W-1:0]      rd0_idx,
  output line_st_e              rd0_st,
  output logic [TAG_W-1:0]      rd0_tag,
  input  logic [IDX_W-1:0]      rd1_idx,
  output line_st_e              rd1_st,
  output logic [TAG_W-1:0]      rd1_tag,
  output logic [2*NLINES-1:0]   st_flat
);

  line_st_e           st_q  [NLINES];
  logic [TAG_W-1:0]   tag_q [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
      end else if (a_we && (a_idx == IDX_W'(i))) begin
        // controller updates win over snoop updates
        st_q[i] <= a_st;
        if (a_tag_we) tag_q[i] <= a_tag;
      end else if (s_we && (s_idx == IDX_W'(i))) begin
        st_q[i] <= s_st;
      end
    end
    assign st_flat[2*i +: 2] = st_q[i];
  end

  assign rd0_st  = st_q[rd0_idx];
  assign rd0_tag = tag_q[rd0_idx];
  assign rd1_st  = st_q[rd1_idx];
  assign rd1_tag = tag_q[rd1_idx];

endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snoop_valid,
  input  bus_op_e           snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              fsm_idle,
  output logic              hold_hit,
  output logic              defer,
  output logic              wb_start,
  output logic              upd_we,
  output line_st_e          upd_st
);

  logic tag_eq;

  assign tag_eq   = line_tag == snoop_addr[ADDR_W-1:IDX_W];
  assign hold_hit = snoop_valid && tag_eq && is_held(line_st);
  assign defer    = hold_hit && is_read_op(snoop_op) && (line_st == LS_MOD);
  assign wb_start = defer && fsm_idle;
  assign upd_st   = snoop_next(line_st, snoop_op);
  assign upd_we   = hold_hit && (upd_st != line_st);

endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              snoop_valid,
  input  logic              snoop_wb_start,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              bus_done,
  input  logic              bus_shared,
  output logic              bus_req_valid,
  output bus_op_e           bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              fsm_idle,
  output logic              a_we,
  output logic [IDX_W-1:0]  a_idx,
  output logic              a_tag_we,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st
);

  typedef enum logic [2:0] {
    F_IDLE, F_VICWB, F_FILL, F_UPG, F_SNPWB
  } fsm_e;

  fsm_e              st_q, st_d;
  logic [ADDR_W-1:0] fill_addr_q, fill_addr_d;
  logic [ADDR_W-1:0] bus_addr_q, bus_addr_d;
  bus_op_e           op_q, op_d;
  logic              wr_q, wr_d;

  logic [IDX_W-1:0]  cpu_idx, fill_idx;
  logic [TAG_W-1:0]  cpu_tag, fill_tag;
  logic              line_hit;

  assign cpu_idx  = cpu_addr[IDX_W-1:0];
  assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr_q[IDX_W-1:0];
  assign fill_tag = fill_addr_q[ADDR_W-1:IDX_W];
  assign lk_idx   = (st_q == F_IDLE) ? cpu_idx : fill_idx;
  assign line_hit = is_held(lk_st) && (lk_tag == cpu_tag);

  always_comb begin
    st_d        = st_q;
    fill_addr_d = fill_addr_q;
    bus_addr_d  = bus_addr_q;
    op_d        = op_q;
    wr_d        = wr_q;
    cpu_ready   = 1'b0;
    a_we        = 1'b0;
    a_idx       = fill_idx;
    a_tag_we    = 1'b0;
    a_tag       = fill_tag;
    a_st        = LS_INV;
    case (st_q)
      F_IDLE: begin
        if (snoop_wb_start) begin
          st_d       = F_SNPWB;
          bus_addr_d = snoop_addr;
          op_d       = BUS_WB;
        end else if (cpu_valid && !snoop_valid) begin
          fill_addr_d = cpu_addr;
          wr_d        = cpu_write;
          if (line_hit && (!cpu_write || can_write(lk_st))) begin
            cpu_ready = 1'b1;
            if (cpu_write && (lk_st == LS_EXC)) begin
              a_we  = 1'b1;
              a_idx = cpu_idx;
              a_st  = LS_MOD;
            end
          end else if (line_hit) begin
            st_d       = F_UPG;
            bus_addr_d = cpu_addr;
            op_d       = BUS_INV;
          end else if (lk_st == LS_MOD) begin
            st_d       = F_VICWB;
            bus_addr_d = {lk_tag, cpu_idx};
            op_d       = BUS_WB;
          end else begin
            st_d       = F_FILL;
            bus_addr_d = cpu_addr;
            op_d       = cpu_write ? BUS_RDX : BUS_RDS;
          end
        end
      end
      F_VICWB: if (bus_done) begin
        a_we       = 1'b1;
        a_st       = LS_INV;
        st_d       = F_FILL;
        bus_addr_d = fill_addr_q;
        op_d       = wr_q ? BUS_RDX : BUS_RDS;
      end
      F_FILL: if (bus_done) begin
        a_we     = 1'b1;
        a_tag_we = 1'b1;
        a_st     = fill_state(wr_q, bus_shared);
        st_d     = F_IDLE;
      end
      F_UPG: if (bus_done) begin
        // ownership only if the copy survived the wait
        if ((lk_st == LS_SHD) && (lk_tag == fill_tag)) begin
          a_we = 1'b1;
          a_st = LS_MOD;
        end
        st_d = F_IDLE;
      end
      F_SNPWB: if (bus_done) begin
        a_we  = 1'b1;
        a_idx = bus_addr_q[IDX_W-1:0];
        a_st  = LS_SHD;
        st_d  = F_IDLE;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      fill_addr_q <= '0;
      bus_addr_q  <= '0;
      op_q        <= BUS_RDS;
      wr_q        <= 1'b0;
    end else begin
      st_q        <= st_d;
      fill_addr_q <= fill_addr_d;
      bus_addr_q  <= bus_addr_d;
      op_q        <= op_d;
      wr_q        <= wr_d;
    end
  end

  assign bus_req_valid = st_q != F_IDLE;
  assign bus_req_op    = op_q;
  assign bus_req_addr  = bus_addr_q;
  assign fsm_idle      = st_q == F_IDLE;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_done,
  input  logic              bus_shared,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              snoop_defer
);

  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int NLINES = 1 << IDX_W;

  // named internal events, also observed by the bound checker
  logic [2*NLINES-1:0] line_st_flat;
  logic                fsm_idle;
  logic                snoop_wb_start;

  logic [IDX_W-1:0]    lk_idx;
  line_st_e            lk_st, sn_st, a_st, upd_st;
  logic [TAG_W-1:0]    lk_tag, sn_tag, a_tag;
  logic                a_we, a_tag_we, upd_we;
  logic [IDX_W-1:0]    a_idx;
  bus_op_e             req_op;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_we     (a_we),
    .a_idx    (a_idx),
    .a_tag_we (a_tag_we),
    .a_tag    (a_tag),
    .a_st     (a_st),
    .s_we     (upd_we),
    .s_idx    (snoop_addr[IDX_W-1:0]),
    .s_st     (upd_st),
    .rd0_idx  (lk_idx),
    .rd0_st   (lk_st),
    .rd0_tag  (lk_tag),
    .rd1_idx  (snoop_addr[IDX_W-1:0]),
    .rd1_st   (sn_st),
    .rd1_tag  (sn_tag),
    .st_flat  (line_st_flat)
  );

  mesi_snoop_eval #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_op    (bus_op_e'(snoop_op)),
    .snoop_addr  (snoop_addr),
    .line_st     (sn_st),
    .line_tag    (sn_tag),
    .fsm_idle    (fsm_idle),
    .hold_hit    (snoop_shared),
    .defer       (snoop_defer),
    .wb_start    (snoop_wb_start),
    .upd_we      (upd_we),
    .upd_st      (upd_st)
  );

  mesi_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_valid      (cpu_valid),
    .cpu_write      (cpu_write),
    .cpu_addr       (cpu_addr),
    .cpu_ready      (cpu_ready),
    .lk_idx         (lk_idx),
    .lk_st          (lk_st),
    .lk_tag         (lk_tag),
    .snoop_valid    (snoop_valid),
    .snoop_wb_start (snoop_wb_start),
    .snoop_addr     (snoop_addr),
    .bus_done       (bus_done),
    .bus_shared     (bus_shared),
    .bus_req_valid  (bus_req_valid),
    .bus_req_op     (req_op),
    .bus_req_addr   (bus_req_addr),
    .fsm_idle       (fsm_idle),
    .a_we           (a_we),
    .a_idx          (a_idx),
    .a_tag_we       (a_tag_we),
    .a_tag          (a_tag),
    .a_st           (a_st)
  );

  assign bus_req_op = req_op;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int NLINES = 1 << IDX_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_valid,
  input logic                cpu_write,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                cpu_ready,
  input logic                bus_req_valid,
  input logic [1:0]          bus_req_op,
  input logic [ADDR_W-1:0]   bus_req_addr,
  input logic                bus_done,
  input logic                snoop_valid,
  input logic [1:0]          snoop_op,
  input logic [ADDR_W-1:0]   snoop_addr,
  input logic                snoop_defer,
  input logic                fsm_idle,
  input logic [2*NLINES-1:0] line_st_flat
);

  function automatic logic [1:0] st_at(logic [2*NLINES-1:0] f, logic [IDX_W-1:0] i);
    return f[2*i +: 2];
  endfunction

  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_done) |=>
      (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr)));

  assert_ready_only_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_valid && !bus_req_valid && !snoop_valid));

  assert_write_hit_modified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_write) |=>
      (st_at(line_st_flat, $past(cpu_addr[IDX_W-1:0])) == 2'b11));

  assert_read_hit_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_write) |=>
      (st_at(line_st_flat, $past(cpu_addr[IDX_W-1:0])) ==
       $past(st_at(line_st_flat, cpu_addr[IDX_W-1:0]))));

  assert_defer_starts_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_defer && fsm_idle) |=>
      (bus_req_valid && (bus_req_op == 2'b11) && (bus_req_addr == $past(snoop_addr))));

  assert_defer_on_reads_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_defer |-> (snoop_valid && (snoop_op[1] == 1'b0)));

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_valid     (cpu_valid),
  .cpu_write     (cpu_write),
  .cpu_addr      (cpu_addr),
  .cpu_ready     (cpu_ready),
  .bus_req_valid (bus_req_valid),
  .bus_req_op    (bus_req_op),
  .bus_req_addr  (bus_req_addr),
  .bus_done      (bus_done),
  .snoop_valid   (snoop_valid),
  .snoop_op      (snoop_op),
  .snoop_addr    (snoop_addr),
  .snoop_defer   (snoop_defer),
  .fsm_idle      (fsm_idle),
  .line_st_flat  (line_st_flat)
);

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int NL     = 4;
  // bench-side state names
  localparam int MI = 0, MS = 1, ME = 2, MM = 3;
  localparam int OP_RDS = 0, OP_RDX = 1, OP_INV = 2, OP_WB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_ready;
  logic bus_req_valid;
  logic [1:0] bus_req_op;
  logic [ADDR_W-1:0] bus_req_addr;
  logic bus_done = 1'b0, bus_shared = 1'b0;
  logic snoop_valid = 1'b0;
  logic [1:0] snoop_op = '0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic snoop_shared, snoop_defer;

  mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
    .bus_done(bus_done), .bus_shared(bus_shared),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
    .snoop_shared(snoop_shared), .snoop_defer(snoop_defer)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // reference model: resident address and state per slot
  int res_addr [NL];
  int res_st   [NL];

  function automatic int m_st(int a);
    int i = a % NL;
    return (res_addr[i] == a) ? res_st[i] : MI;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered 1 unit after a falling edge with the request expected on the bus
  task automatic bus_phase(int op, int addr, bit shr, string req);
    chk({req, " bus valid"}, int'(bus_req_valid), 1);
    chk({req, " bus op"}, int'(bus_req_op), op);
    chk({req, " bus addr"}, int'(bus_req_addr), addr);
    chk({req, " R12 ready low while pending"}, int'(cpu_ready), 0);
    @(negedge clk); #1;
    chk({req, " R12 op held"}, int'(bus_req_op), op);
    chk({req, " R12 addr held"}, int'(bus_req_addr), addr);
    @(negedge clk);
    bus_done = 1'b1; bus_shared = shr;
    #1;
    chk({req, " R12 still valid"}, int'(bus_req_valid), 1);
    @(negedge clk);
    bus_done = 1'b0; bus_shared = 1'b0;
    #1;
  endtask

  task automatic access(int addr, bit wr, bit shr, string req);
    int i = addr % NL;
    int s = m_st(addr);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = ADDR_W'(addr);
    #1;
    if (s != MI && (!wr || s >= ME)) begin
      chk({req, " hit ready"}, int'(cpu_ready), 1);
      if (wr) res_st[i] = MM;
      @(negedge clk); cpu_valid = 1'b0; #1;
      chk({req, " no bus after hit"}, int'(bus_req_valid), 0);
    end else begin
      chk({req, " miss ready low"}, int'(cpu_ready), 0);
      @(negedge clk); #1;
      if (s == MS) begin
        bus_phase(OP_INV, addr, 1'b0, req);
        res_st[i] = MM;
      end else begin
        if (res_st[i] == MM) begin
          bus_phase(OP_WB, res_addr[i], 1'b0, {req, " R11 victim"});
          res_st[i] = MI;
        end
        bus_phase(wr ? OP_RDX : OP_RDS, addr, shr, req);
        res_addr[i] = addr;
        res_st[i] = wr ? MM : (shr ? MS : ME);
      end
      chk({req, " ready after completion"}, int'(cpu_ready), 1);
      @(negedge clk); cpu_valid = 1'b0; #1;
    end
  endtask

  task automatic snoop(int op, int addr, string req);
    int i = addr % NL;
    int s = m_st(addr);
    bit dfr = (op == OP_RDS || op == OP_RDX) && s == MM;
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = 2'(op); snoop_addr = ADDR_W'(addr);
    #1;
    chk({req, " R5 held indication"}, int'(snoop_shared), int'(s != MI));
    chk({req, " R6 defer"}, int'(snoop_defer), int'(dfr));
    @(negedge clk); snoop_valid = 1'b0; #1;
    if (dfr) begin
      bus_phase(OP_WB, addr, 1'b0, {req, " R6 snoop writeback"});
      res_st[i] = MS;
    end else if (s != MI) begin
      if (op == OP_RDS && s == ME) res_st[i] = MS;
      if ((op == OP_RDX || op == OP_INV) && (s == MS || s == ME)) res_st[i] = MI;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    for (int k = 0; k < NL; k++) begin res_addr[k] = -1; res_st[k] = MI; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ready idle", int'(cpu_ready), 0);
    chk("R1 no bus request", int'(bus_req_valid), 0);
    snoop(OP_WB, 'h10, "R1 probe after reset");

    access('h10, 1'b0, 1'b0, "R9 read miss exclusive");
    snoop(OP_WB, 'h10, "R9 probe held");
    access('h10, 1'b0, 1'b0, "R2 read hit");
    access('h10, 1'b1, 1'b0, "R3 silent write on exclusive");
    snoop(OP_RDS, 'h10, "R6 read hits modified idle");
    access('h10, 1'b0, 1'b0, "R2 read hit shared");
    access('h10, 1'b1, 1'b0, "R4 upgrade");
    snoop(OP_RDX, 'h10, "R6 ownership read hits modified");
    snoop(OP_RDX, 'h10, "R7 ownership read drops shared");
    snoop(OP_WB, 'h10, "R7 probe dropped");

    access('h25, 1'b0, 1'b1, "R9 read miss shared");
    snoop(OP_RDS, 'h25, "R5 peer read on shared");
    access('h25, 1'b1, 1'b0, "R8 shared never exclusive");

    access('h3A, 1'b1, 1'b0, "R10 write miss");
    snoop(OP_WB, 'h3A, "R10 probe held");
    access('h7A, 1'b0, 1'b0, "R11 dirty eviction");
    snoop(OP_WB, 'h3A, "R11 victim gone");
    access('h4A, 1'b0, 1'b0, "R11 clean eviction");
    snoop(OP_RDS, 'h4A, "R5 exclusive to shared");
    snoop(OP_INV, 'h4A, "R7 invalidate drops shared");
    snoop(OP_WB, 'h4A, "R7 probe after invalidate");

    // R12 processor held off by a concurrent snoop
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h25;
    snoop_valid = 1'b1; snoop_op = 2'(OP_WB); snoop_addr = 8'h55;
    #1;
    chk("R12 stalled by snoop", int'(cpu_ready), 0);
    @(negedge clk); snoop_valid = 1'b0; #1;
    chk("R2 hit after snoop", int'(cpu_ready), 1);
    @(negedge clk); cpu_valid = 1'b0; #1;

    // R6 defer while busy: no writeback started
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h10;
    #1;
    chk("R9 miss ready low", int'(cpu_ready), 0);
    @(negedge clk); #1;
    chk("R9 fill op", int'(bus_req_op), OP_RDS);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = 2'(OP_RDS); snoop_addr = 8'h25;
    #1;
    chk("R6 busy defer", int'(snoop_defer), 1);
    @(negedge clk); snoop_valid = 1'b0; #1;
    chk("R6 busy no writeback op", int'(bus_req_op), OP_RDS);
    chk("R6 busy no writeback addr", int'(bus_req_addr), 'h10);
    @(negedge clk); bus_done = 1'b1; #1;
    @(negedge clk); bus_done = 1'b0; #1;
    chk("R9 ready after fill", int'(cpu_ready), 1);
    res_addr[0] = 'h10; res_st[0] = ME;
    @(negedge clk); cpu_valid = 1'b0; #1;
    snoop(OP_RDS, 'h25, "R6 retried read now idle");

    // R13 upgrade lost to a peer invalidate
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 8'h25;
    #1;
    chk("R4 upgrade ready low", int'(cpu_ready), 0);
    @(negedge clk); #1;
    chk("R4 invalidate op", int'(bus_req_op), OP_INV);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = 2'(OP_INV); snoop_addr = 8'h25;
    #1;
    chk("R13 peer invalidate sees copy", int'(snoop_shared), 1);
    @(negedge clk); snoop_valid = 1'b0; bus_done = 1'b1; #1;
    @(negedge clk); bus_done = 1'b0; #1;
    chk("R13 no ownership after loss", int'(cpu_ready), 0);
    @(negedge clk); #1;
    bus_phase(OP_RDX, 'h25, 1'b0, "R13 reissued as ownership read");
    res_addr[1] = 'h25; res_st[1] = MM;
    chk("R13 ready after refill", int'(cpu_ready), 1);
    @(negedge clk); cpu_valid = 1'b0; #1;
    snoop(OP_RDS, 'h25, "R13 line now modified");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule